// File: doc/BRIEF.md
# Serial Position Readout Shift Register

This block hands a parallel absolute position word to an external host over a narrow serial link. The host drives three signals: a level-sensitive load/shift control, a serial clock and a serial data input. The block returns one serial data output.

While the control is high, the block keeps taking the current position word into its shift register. When the control drops, that word is frozen. Each rising serial clock edge then moves the word one place towards the output, most significant bit first.

Bits taken in on the serial input enter at the tail of the register, behind the local word. Devices can therefore be chained, or the output can be looped back to the input to form a ring. The host picks the word length by the number of clock pulses it gives. A direction-select input inverts the top bit of the word as it leaves, which reverses the counting direction.

The host signals come from outside the system clock domain. Each passes through a synchronizer, and clock edges are detected on the synchronized copies. All of the block's logic runs on a faster system clock. The serial output is a register.

Top module: `posrd_serializer`

## Requirements
- R1: During synchronous reset, and until the first load, the serial output is 0.
- R2: While the load control is 1, the serial output shows bit 15 of the current position word. It follows changes of that word within 4 system clocks.
- R3: Once the load control is 0, changes of the position word do not alter the bits shifted out. The frame holds the word present in the last load cycle.
- R4: Each synchronized rising edge of the serial clock in shift mode advances the word by one place. After k edges (1 to 15), the output shows word bit 15-k, so the frame runs from bit 15 down to bit 0.
- R5: With the direction select at 1, only the first bit of a frame (word bit 15) is inverted at the output. All later bits pass unchanged.
- R6: A host may stop after 12 to 15 clock pulses and return to load mode. The next frame is complete and correct.
- R7: Serial input bits are taken in on each shift edge. The bit taken at edge j appears at the output after edge j+15, uninverted.
- R8: Serial clock edges received while the load control is 1 do not shift the register.
- R9: A serial clock edge that arrives in the same synchronized cycle as the fall of the load control shifts the word captured in the last load cycle. Afterwards the output shows word bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_word | input | W | Parallel position word, bit W-1 most significant |
| host_load | input | 1 | Host load (1) / shift (0) control, asynchronous |
| host_sclk | input | 1 | Host serial clock, asynchronous |
| host_sdi | input | 1 | Serial input feeding the register tail |
| dir_inv | input | 1 | 1 inverts the first (top) bit of each frame |
| sdo | output | 1 | Registered serial output |

## Verification
The capture of a new word and the first shift can fall in the same system-clock cycle. This happens when the host lowers the load control and raises the serial clock at the same moment. Both pass through synchronizers of equal depth, so they arrive together. The bench provokes this case directly: it holds the position word steady and then requires the output to show bit 14 of that word. A dropped shift would leave bit 15 at the output, and a recapture would leave the register unshifted.

// File: rtl/posrd_pkg.sv
package posrd_pkg;
  typedef enum logic {
    SR_SHIFT = 1'b0,
    SR_LOAD  = 1'b1
  } sr_mode_e;
endpackage

// File: rtl/posrd_sync.sv
module posrd_sync #(
  parameter int N      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= '0;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/posrd_edge.sv
module posrd_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/posrd_shifter.sv
module posrd_shifter
  import posrd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  sr_mode_e     mode,
  input  logic         step,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] word,
  output logic         fresh
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      fresh <= 1'b0;
    end else if (mode == SR_LOAD) begin
      word  <= par_in;
      fresh <= 1'b1;
    end else if (step) begin
      word  <= {word[W-2:0], ser_in};
      fresh <= 1'b0;
    end
  end
endmodule

// File: rtl/posrd_serializer.sv
module posrd_serializer
  import posrd_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pos_word,
  input  logic         host_load,
  input  logic         host_sclk,
  input  logic         host_sdi,
  input  logic         dir_inv,
  output logic         sdo
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in;
  logic [NSYNC-1:0] sync_out;
  logic             ld_s;
  logic             sclk_s;
  logic             sdi_s;
  logic             rise;
  sr_mode_e         mode;
  logic [W-1:0]     word;
  logic             fresh;

  assign raw_in = {host_sdi, host_sclk, host_load};

  posrd_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign ld_s   = sync_out[0];
  assign sclk_s = sync_out[1];
  assign sdi_s  = sync_out[2];

  posrd_edge u_edge (
    .clk(clk), .rst(rst), .lvl(sclk_s), .rise(rise)
  );

  assign mode = ld_s ? SR_LOAD : SR_SHIFT;

  posrd_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .mode(mode), .step(rise), .ser_in(sdi_s),
    .par_in(pos_word), .word(word), .fresh(fresh)
  );

  always_ff @(posedge clk) begin
    if (rst) sdo <= 1'b0;
    else     sdo <= word[W-1] ^ (dir_inv & fresh);
  end
endmodule

// File: rtl/posrd_serializer_chk.sv
module posrd_serializer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ld_s,
  input logic         rise,
  input logic         sdi_s,
  input logic         fresh,
  input logic [W-1:0] word,
  input logic [W-1:0] pos_word,
  input logic         sdo
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (sdo == 1'b0 && word == '0));

  p_load_track_r2: assert property (@(posedge clk) disable iff (rst)
    ld_s |=> word == $past(pos_word));

  p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld_s && !rise) |=> $stable(word));

  p_shift_r4: assert property (@(posedge clk) disable iff (rst)
    (!ld_s && rise) |=> word[W-1:1] == $past(word[W-2:0]));

  p_first_only_r5: assert property (@(posedge clk) disable iff (rst)
    (!ld_s && rise) |=> !fresh);

  p_tail_in_r7: assert property (@(posedge clk) disable iff (rst)
    (!ld_s && rise) |=> word[0] == $past(sdi_s));

  p_fresh_from_load_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fresh) |-> $past(ld_s));
endmodule

bind posrd_serializer posrd_serializer_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ld_s(ld_s), .rise(rise), .sdi_s(sdi_s),
  .fresh(fresh), .word(word), .pos_word(pos_word), .sdo(sdo)
);

// File: tb/posrd_serializer_tb.sv
`timescale 1ns/1ps
module posrd_serializer_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pos_word = '0;
  logic         host_load = 1'b0;
  logic         host_sclk = 1'b0;
  logic         host_sdi = 1'b0;
  logic         dir_inv = 1'b0;
  logic         sdo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  posrd_serializer #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .pos_word(pos_word), .host_load(host_load),
    .host_sclk(host_sclk), .host_sdi(host_sdi), .dir_inv(dir_inv), .sdo(sdo)
  );

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sdo=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic first_bit(input logic [W-1:0] w, input logic inv);
    return w[W-1] ^ inv;
  endfunction

  task automatic frame(input logic [W-1:0] w, input logic inv, input int nclk,
                       input bit merge, input bit after_short);
    logic hist [64];
    pos_word = w; dir_inv = inv; host_load = 1'b1;
    wait_clks(8);
    chk(inv ? "R5" : "R2", sdo, first_bit(w, inv));
    if (!merge) begin
      host_load = 1'b0;
      wait_clks(8);
      pos_word = w ^ W'($urandom | 1);
      wait_clks(8);
      chk("R3", sdo, first_bit(w, inv));
    end
    for (int k = 1; k <= nclk; k++) begin
      hist[k] = 1'($urandom);
      host_sdi = hist[k];
      if (merge && k == 1) host_load = 1'b0;
      host_sclk = 1'b1;
      wait_clks(8);
      host_sclk = 1'b0;
      wait_clks(8);
      if (k < W) begin
        if (merge && k == 1) chk("R9", sdo, w[W-1-k]);
        else if (after_short) chk("R6", sdo, w[W-1-k]);
        else if (inv) chk("R5", sdo, w[W-1-k]);
        else chk("R4", sdo, w[W-1-k]);
      end else begin
        chk("R7", sdo, hist[k-W+1]);
      end
    end
    host_load = 1'b1;
    wait_clks(8);
  endtask

  task automatic load_pulses(input logic [W-1:0] w, input logic inv);
    pos_word = w; dir_inv = inv; host_load = 1'b1;
    wait_clks(8);
    for (int p = 0; p < 3; p++) begin
      host_sclk = 1'b1; wait_clks(8);
      host_sclk = 1'b0; wait_clks(8);
      chk("R8", sdo, first_bit(w, inv));
    end
    host_load = 1'b0;
    wait_clks(8);
    host_sclk = 1'b1; wait_clks(8);
    host_sclk = 1'b0; wait_clks(8);
    chk("R8", sdo, w[W-2]);
    host_load = 1'b1;
    wait_clks(8);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    wait_clks(3);
    chk("R1", sdo, 1'b0);
    @(negedge clk) rst = 1'b0;
    wait_clks(6);
    chk("R1", sdo, 1'b0);

    frame(16'hA5C3, 1'b0, 16, 1'b0, 1'b0);
    frame(16'h8001, 1'b1, 16, 1'b0, 1'b0);
    frame(16'h7FFE, 1'b1, 20, 1'b0, 1'b0);
    frame(16'h4000, 1'b0, 1, 1'b1, 1'b0);
    frame(16'hC3A5, 1'b1, 16, 1'b1, 1'b0);
    load_pulses(16'h9234, 1'b0);
    load_pulses(16'h1BCD, 1'b1);
    for (int n = 0; n < 12; n++) begin
      logic [W-1:0] w;
      int len;
      w   = W'($urandom);
      len = 12 + int'($urandom % 4);
      frame(w, 1'($urandom), len, 1'b0, 1'b0);
      frame(W'($urandom), 1'($urandom), 16 + int'($urandom % 8), 1'($urandom), 1'b1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule